// File: doc/BRIEF.md
# Reset qualification and boot-mode selection controller

This block sits between the raw reset and strobe pins of a microcontroller and the rest of the device. Both pins are brought into the oscillator clock domain through synchronisers. A reset pulse is honoured only if it lasts at least two machine cycles, where one machine cycle is twelve oscillator periods. Shorter glitches are dropped without side effects.

While a qualified reset is being held, the block watches the strobe pin. A high-to-low transition on that pin, seen after the reset pin has been high for more than ten machine cycles, chooses the external-host flash programming mode. If no such edge arrives, the device leaves reset in normal mode. The mode is frozen when reset is released. The block also provides the external-access select that the fetch logic uses. When the security lock input is set, this is the pin level captured during reset. Otherwise the live pin level passes through.

The controller is a four-state machine:
- `ST_RUN`: out of reset.
- `ST_QUAL`: the reset pin is high but the pulse is not yet qualified.
- `ST_HELD`: qualified reset, normal mode pending.
- `ST_HOST`: qualified reset, host mode selected.

Transitions:
- **start**: `ST_RUN` to `ST_QUAL` when the synchronised reset goes high.
- **abort**: `ST_QUAL` to `ST_RUN` when it drops early.
- **qualify**: `ST_QUAL` to `ST_HELD` in the 24th consecutive high cycle.
- **select**: `ST_HELD` to `ST_HOST` on an armed strobe fall.
- **release_normal**: `ST_HELD` to `ST_RUN`.
- **release_host**: `ST_HOST` to `ST_RUN`.

Top module: `rst_mode_ctrl`

## Requirements
Edges are numbered from the first rising clock edge at which the reset pin is sampled high (edge 1). N is the last edge at which the reset pin is sampled high. F is the first edge at which the strobe pin is sampled low. The strobe pin idles high.
- R1: After `arst_ni` is released, `sys_rst_o` = 0 and `host_mode_o` = 0. With `sec_lock_i` = 1, `ea_sel_o` = 0 because the latch is cleared.
- R2: A reset-pin pulse with N <= 23 never raises `sys_rst_o`. It leaves `host_mode_o` unchanged and leaves the latched access level unchanged.
- R3: With N >= 24, `sys_rst_o` is still 0 after edge 25 and is 1 after edge 26.
- R4: With N >= 24, `sys_rst_o` is 1 after edge N+2 and 0 after edge N+3. `host_mode_o` takes its new value at edge N+3.
- R5: With 121 <= F <= N, the reset ends with `host_mode_o` = 1.
- R6: A strobe fall with F <= 120 is ignored, and the reset ends with `host_mode_o` = 0.
- R7: A qualified reset with no strobe fall ends with `host_mode_o` = 0, even if it was 1 before.
- R8: Strobe activity while out of reset leaves `host_mode_o` unchanged.
- R9: The hold count saturates. For a reset held 300 cycles with F = 290, the reset ends with `host_mode_o` = 1.
- R10: With `sec_lock_i` = 0, `ea_sel_o` equals `ea_pin_i` combinationally.
- R11: With `sec_lock_i` = 1, `ea_sel_o` holds the `ea_pin_i` level sampled at the last cycle of a qualified reset (edge N+3). Later pin changes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| arst_ni | input | 1 | Power-on asynchronous reset of the controller, active low |
| rst_pin_i | input | 1 | Raw reset pin, active high, asynchronous |
| strobe_pin_i | input | 1 | Raw strobe pin, asynchronous, idles high |
| ea_pin_i | input | 1 | External-access select pin level |
| sec_lock_i | input | 1 | Security lock active |
| sys_rst_o | output | 1 | Qualified device reset |
| host_mode_o | output | 1 | 1 = external-host programming mode, 0 = normal |
| ea_sel_o | output | 1 | Effective external-access select |

## Verification
The hardest situations to reach from the ports are the strobe edge landing exactly on the ten-machine-cycle threshold, and a reset held long enough that a wrapping counter would lose the armed condition. Directed pulses place the strobe fall at F = 120 and F = 121, and at F = 290 of a 300-cycle hold, with the expected mode computed from the edge numbering. Seeded random pulse lengths and strobe positions are mixed in as well. A 23-cycle pulse that follows a host-mode reset shows that an unqualified pulse disturbs neither the mode nor the latch.

// File: rtl/rmc_pkg.sv
package rmc_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_QUAL = 2'd1,
        ST_HELD = 2'd2,
        ST_HOST = 2'd3
    } rmc_state_e;
endpackage

// File: rtl/rmc_sync.sv
module rmc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic arst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk_i or negedge arst_ni) begin
            if (!arst_ni) begin
                chain_q[s] <= RST_VAL;
            end else if (s == 0) begin
                chain_q[s] <= d_i;
            end else begin
                chain_q[s] <= chain_q[(s > 0) ? s-1 : 0];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rmc_fall_det.sv
module rmc_fall_det (
    input  logic clk_i,
    input  logic arst_ni,
    input  logic sig_i,
    output logic fall_o
);
    logic prev_q;

    always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= sig_i;
        end
    end

    assign fall_o = prev_q & ~sig_i;
endmodule

// File: rtl/rmc_hold_timer.sv
module rmc_hold_timer #(
    parameter int CNT_W   = 7,
    parameter int SAT_VAL = 120
) (
    input  logic             clk_i,
    input  logic             arst_ni,
    input  logic             level_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] SAT = CNT_W'(SAT_VAL);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) begin
            cnt_q <= '0;
        end else if (!level_i) begin
            cnt_q <= '0;
        end else if (cnt_q != SAT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/rst_mode_ctrl.sv
module rst_mode_ctrl #(
    parameter int SYNC_STAGES = 2,
    parameter int CYC_PER_MC  = 12,
    parameter int QUAL_MC     = 2,
    parameter int HOST_MC     = 10
) (
    input  logic clk_i,
    input  logic arst_ni,
    input  logic rst_pin_i,
    input  logic strobe_pin_i,
    input  logic ea_pin_i,
    input  logic sec_lock_i,
    output logic sys_rst_o,
    output logic host_mode_o,
    output logic ea_sel_o
);
    import rmc_pkg::*;

    localparam int QUAL_LIM = QUAL_MC * CYC_PER_MC;
    localparam int HOST_LIM = HOST_MC * CYC_PER_MC;
    localparam int CNT_W    = $clog2(HOST_LIM + 1);
    localparam logic [CNT_W-1:0] QUAL_M1 = CNT_W'(QUAL_LIM - 1);
    localparam logic [CNT_W-1:0] ARM_AT  = CNT_W'(HOST_LIM);

    logic             rst_s;
    logic             stb_s;
    logic             stb_fall;
    logic [CNT_W-1:0] hold_cnt;
    logic             qual_now;
    logic             armed;
    logic             in_rst;
    logic             release_now;
    logic             mode_q;
    logic             ea_lat_q;
    rmc_state_e       state_q;
    rmc_state_e       state_d;

    rmc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
        .clk_i(clk_i), .arst_ni(arst_ni), .d_i(rst_pin_i), .q_o(rst_s)
    );

    rmc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_stb_sync (
        .clk_i(clk_i), .arst_ni(arst_ni), .d_i(strobe_pin_i), .q_o(stb_s)
    );

    rmc_fall_det u_stb_fall (
        .clk_i(clk_i), .arst_ni(arst_ni), .sig_i(stb_s), .fall_o(stb_fall)
    );

    rmc_hold_timer #(.CNT_W(CNT_W), .SAT_VAL(HOST_LIM)) u_hold (
        .clk_i(clk_i), .arst_ni(arst_ni), .level_i(rst_s), .cnt_o(hold_cnt)
    );

    // this cycle is the QUAL_LIM-th consecutive synchronised high cycle
    assign qual_now    = rst_s && (hold_cnt >= QUAL_M1);
    assign armed       = hold_cnt >= ARM_AT;
    assign in_rst      = (state_q == ST_HELD) || (state_q == ST_HOST);
    assign release_now = in_rst && !rst_s;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (rst_s) state_d = ST_QUAL;
            ST_QUAL: begin
                if (!rst_s)        state_d = ST_RUN;
                else if (qual_now) state_d = ST_HELD;
            end
            ST_HELD: begin
                if (!rst_s)                 state_d = ST_RUN;
                else if (armed && stb_fall) state_d = ST_HOST;
            end
            ST_HOST: if (!rst_s) state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) begin
            mode_q   <= 1'b0;
            ea_lat_q <= 1'b0;
        end else begin
            if (in_rst) begin
                ea_lat_q <= ea_pin_i;
            end
            if (release_now) begin
                mode_q <= (state_q == ST_HOST);
            end
        end
    end

    assign sys_rst_o   = in_rst;
    assign host_mode_o = mode_q;
    assign ea_sel_o    = sec_lock_i ? ea_lat_q : ea_pin_i;
endmodule

// File: rtl/rmc_chk.sv
module rmc_chk #(
    parameter int CNT_W    = 7,
    parameter int QUAL_LIM = 24,
    parameter int HOST_LIM = 120
) (
    input logic               clk_i,
    input logic               arst_ni,
    input logic               sys_rst_o,
    input logic               host_mode_o,
    input logic               ea_sel_o,
    input logic               ea_pin_i,
    input logic               sec_lock_i,
    input logic               rst_s,
    input logic [CNT_W-1:0]   hold_cnt,
    input rmc_pkg::rmc_state_e state_q
);
    import rmc_pkg::*;

    // R3
    rst_needs_qual_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
        $rose(sys_rst_o) |-> ($past(hold_cnt) >= CNT_W'(QUAL_LIM - 1)));

    // R4
    mode_only_on_release_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
        !$stable(host_mode_o) |-> $fell(sys_rst_o));

    // R5
    host_needs_arm_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
        $rose(state_q == ST_HOST) |-> ($past(hold_cnt) >= CNT_W'(HOST_LIM)));

    // R9
    cnt_saturate_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
        (rst_s && hold_cnt == CNT_W'(HOST_LIM)) |=> (hold_cnt == CNT_W'(HOST_LIM)));

    // R10
    ea_pass_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
        !sec_lock_i |-> (ea_sel_o == ea_pin_i));

    // R11
    ea_hold_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
        (sec_lock_i && $past(sec_lock_i) && !sys_rst_o && $past(!sys_rst_o))
        |-> $stable(ea_sel_o));
endmodule

bind rst_mode_ctrl rmc_chk #(
    .CNT_W(CNT_W), .QUAL_LIM(QUAL_LIM), .HOST_LIM(HOST_LIM)
) u_chk (
    .clk_i(clk_i), .arst_ni(arst_ni), .sys_rst_o(sys_rst_o),
    .host_mode_o(host_mode_o), .ea_sel_o(ea_sel_o), .ea_pin_i(ea_pin_i),
    .sec_lock_i(sec_lock_i), .rst_s(rst_s), .hold_cnt(hold_cnt),
    .state_q(state_q)
);

// File: tb/rst_mode_ctrl_tb.sv
module rst_mode_ctrl_tb;
    logic clk = 1'b0;
    logic arst_n, rst_pin, strobe, ea, lock;
    logic sys_rst, host_mode, ea_sel;
    int   n_run = 0;
    int   n_fail = 0;
    logic mode_m = 1'b0;
    logic lat_m = 1'b0;

    always #10 clk = ~clk;

    rst_mode_ctrl u_dut (
        .clk_i(clk), .arst_ni(arst_n), .rst_pin_i(rst_pin),
        .strobe_pin_i(strobe), .ea_pin_i(ea), .sec_lock_i(lock),
        .sys_rst_o(sys_rst), .host_mode_o(host_mode), .ea_sel_o(ea_sel)
    );

    function automatic logic exp_qual(int n);
        return n >= 24;
    endfunction

    function automatic logic exp_host(int n, int f);
        return (f >= 121) && (f <= n);
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    // n: last edge with reset pin high; f: first edge strobe low (0 = none)
    task automatic pulse(input int n, input int f, input logic lk,
                         input logic ea_a, input logic ea_b, input string tag);
        logic q;
        q = exp_qual(n);
        lock = lk;
        ea = ea_a;
        rst_pin = 1'b1;
        for (int e = 1; e <= n + 6; e++) begin
            @(posedge clk);
            @(negedge clk);
            if (e == 25) check("R3 early", sys_rst, 1'b0);
            if (e == 26) check(q ? "R3" : "R2", sys_rst, q);
            if (q && e == n + 2) check("R4 held", sys_rst, 1'b1);
            if (e == n + 3) check("R4 release", sys_rst, 1'b0);
            if (e == n) rst_pin = 1'b0;
            if (f != 0 && e == f - 1) strobe = 1'b0;
            if (f != 0 && e == f + 3) strobe = 1'b1;
            if (e == n + 4) ea = ea_b;
        end
        if (q) begin
            lat_m  = ea_a;
            mode_m = exp_host(n, f);
        end
        #1;
        check(tag, host_mode, mode_m);
        check(lk ? "R11" : "R10", ea_sel, lk ? lat_m : ea_b);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd1234));
        arst_n = 1'b0; rst_pin = 1'b0; strobe = 1'b1; ea = 1'b0; lock = 1'b0;
        repeat (3) @(negedge clk);
        arst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 rst", sys_rst, 1'b0);
        check("R1 mode", host_mode, 1'b0);
        lock = 1'b1; ea = 1'b1; #1;
        check("R1 ea", ea_sel, 1'b0);
        lock = 1'b0;
        @(negedge clk);

        pulse(150, 121, 1'b1, 1'b1, 1'b0, "R5");
        pulse(23, 0, 1'b1, 1'b0, 1'b0, "R2");
        pulse(150, 120, 1'b0, 1'b0, 1'b1, "R6");
        pulse(300, 290, 1'b1, 1'b0, 1'b1, "R9");
        pulse(40, 0, 1'b1, 1'b1, 1'b0, "R7");
        pulse(24, 0, 1'b0, 1'b1, 1'b0, "R3 min");
        pulse(200, 198, 1'b0, 1'b0, 1'b1, "R5 late");

        // R8: strobe activity out of reset
        strobe = 1'b0;
        repeat (6) @(negedge clk);
        strobe = 1'b1;
        repeat (6) @(negedge clk);
        check("R8 mode", host_mode, mode_m);
        check("R8 rst", sys_rst, 1'b0);

        // R10: live pass-through
        lock = 1'b0;
        for (int i = 0; i < 4; i++) begin
            ea = i[0]; #1;
            check("R10", ea_sel, i[0]);
        end

        for (int k = 0; k < 25; k++) begin
            int n, f;
            n = int'($urandom_range(10, 220));
            f = 0;
            if (n >= 24 && $urandom_range(0, 2) != 0) f = int'($urandom_range(20, n - 2));
            pulse(n, f, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 1)), (n >= 24 && exp_host(n, f)) ? "R5" : "R7");
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule